// File: doc/BRIEF.md
# Core Module Control Register File

This block is the register file of a processor core module. It sits on a simple word-addressed register bus and holds the module's configuration and housekeeping state. There are two oscillator setting registers that only take writes while a 16-bit unlock key is held. A control register drives a status LED and the boot-flash remap, and can issue a reset request. Two flag registers each have a set port and a clear port. A 32-bit reference counter runs at a fixed reference rate derived from the bus clock.

A small local interrupt group holds one software interrupt bit and two enable masks, one for the normal interrupt and one for the fast interrupt. It drives a single interrupt output. A read-only window at word indices 64 to 127 returns bytes of a memory-module identification table.

The bus has no back-pressure. A read or write is taken in the cycle it is presented. Read data arrives one cycle later, marked by a valid strobe. The requester must keep its own count of outstanding reads, because the block cannot stall it.

Top module: `cm_ctrl_regs`

## Requirements
- R1: Writes to word 0 (main oscillator) and word 7 (auxiliary oscillator) change the register only while the lock register holds 0xA05F. Otherwise the write is ignored.
- R2: A write to word 5 stores the low 16 bits of the data. A read of word 5 returns those 16 bits, with bit 16 set exactly while they equal 0xA05F.
- R3: The control register (word 3) stores only data bits 0 and 2 and reads back with all other bits zero. Stored bit 0 drives `status_led`.
- R4: A write to word 3 with data bit 3 set raises `reset_req` for exactly one cycle. Bit 3 always reads back as zero.
- R5: `boot_flash_en` equals the inverse of control bit 2, so it is 1 after reset.
- R6: A write to word 12 ORs the data into the flags register. A write to word 13 clears the flag bits that are 1 in the data. Word 12 reads the flags.
- R7: Words 14 and 15 do the same for the non-volatile flags, which read back at word 14.
- R8: Word 10 reads a 32-bit counter that advances by REF_HZ counts per CLK_HZ clock cycles, never by more than one per cycle. With the defaults (125 MHz and 24 MHz), it advances by exactly 24 over any 125 cycles.
- R9: Words 18 and 26 set, and words 19 and 27 clear, bits of the interrupt and fast-interrupt enable masks. Those masks read at 18 and 26. Words 17 and 25 read the raw level. Words 16 and 24 read the level AND the respective mask.
- R10: The software level is a single bit. A write to word 20 with data bit 0 set sets it, and a write to word 21 with data bit 0 set clears it. Other data bits have no effect. Word 20 reads the level in bit 0.
- R11: `core_int` is high exactly while the level bit is set and bit 0 of either enable mask is set.
- R12: After reset, word 0 reads 0x01000048, word 7 reads 0x0007FEFF, word 8 reads 0x00011122, word 9 reads 0x00000112, and words 3, 5, 12, 14, 18 and 26 read 0.
- R13: A read of word 64+i (i from 0 to 63) returns identification byte i, zero-extended. Byte 0 is 0x80, byte 1 is 0x08, byte 2 is 0x04, byte 31 is MEM_MB/4 (0x20 by default), and every other byte is 0. Writes to the window are ignored.
- R14: `bus_rvalid` is high in the cycle after each read and only then. Reads of unmapped words, including the clear-only ports 13, 15, 19, 21 and 27, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after bus_rd |
| status_led | output | 1 | Control bit 0 |
| boot_flash_en | output | 1 | Boot flash mapped at address zero |
| reset_req | output | 1 | One-cycle reset request |
| core_int | output | 1 | Local interrupt output |

## Verification
Every register takes a write on the clock edge where `bus_wr` is seen. Its effect on `status_led`, `boot_flash_en`, `reset_req` and `core_int` is therefore due one cycle after the write is presented. Read data is due one cycle after `bus_rd`. The driver changes inputs on falling edges, and both the monitor and the pin checks sample on the following falling edge, so each result is observed half a cycle after the edge that produced it. The counter check issues its two reads exactly 125 cycles apart, which makes the expected difference an exact value rather than a range.

// File: rtl/cm_regs_pkg.sv
package cm_regs_pkg;

  // word indices; the bus decodes these exact positions
  localparam int unsigned WI_OSC      = 0;
  localparam int unsigned WI_CTRL     = 3;
  localparam int unsigned WI_LOCK     = 5;
  localparam int unsigned WI_AUXOSC   = 7;
  localparam int unsigned WI_SDRAM    = 8;
  localparam int unsigned WI_INIT     = 9;
  localparam int unsigned WI_COUNT    = 10;
  localparam int unsigned WI_FLAG_SET = 12;
  localparam int unsigned WI_FLAG_CLR = 13;
  localparam int unsigned WI_NV_SET   = 14;
  localparam int unsigned WI_NV_CLR   = 15;
  localparam int unsigned WI_IRQ_STAT = 16;
  localparam int unsigned WI_IRQ_RAW  = 17;
  localparam int unsigned WI_IRQ_ENS  = 18;
  localparam int unsigned WI_IRQ_ENC  = 19;
  localparam int unsigned WI_SOFT_SET = 20;
  localparam int unsigned WI_SOFT_CLR = 21;
  localparam int unsigned WI_FIQ_STAT = 24;
  localparam int unsigned WI_FIQ_RAW  = 25;
  localparam int unsigned WI_FIQ_ENS  = 26;
  localparam int unsigned WI_FIQ_ENC  = 27;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUXOSC_RST = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_RST  = 32'h0001_1122;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;

  // control register bit positions
  localparam int unsigned CB_LED   = 0;
  localparam int unsigned CB_REMAP = 2;
  localparam int unsigned CB_RESET = 3;

  // identification table, computed rather than stored
  function automatic logic [7:0] id_byte(input logic [5:0] idx, input int unsigned mem_mb);
    logic [7:0] b;
    case (idx)
      6'd0:    b = 8'h80;
      6'd1:    b = 8'h08;
      6'd2:    b = 8'h04;
      6'd31:   b = 8'((mem_mb / 4) & 8'hFF);
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST;
    end else if (set_we) begin
      q <= q | wdata;
    end else if (clr_we) begin
      q <= q & ~wdata;
    end
  end
endmodule

// File: rtl/cm_keyed_osc.sv
module cm_keyed_osc
  import cm_regs_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_we,
  input  logic          osc_we,
  input  logic          aux_we,
  input  logic [DW-1:0] wdata,
  output logic [15:0]   lock_q,
  output logic          unlocked,
  output logic [DW-1:0] osc_q,
  output logic [DW-1:0] aux_q
);
  assign unlocked = (lock_q == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      osc_q  <= DW'(OSC_RST);
      aux_q  <= DW'(AUXOSC_RST);
    end else begin
      if (lock_we)             lock_q <= wdata[15:0];
      if (osc_we && unlocked)  osc_q  <= wdata;
      if (aux_we && unlocked)  aux_q  <= wdata;
    end
  end
endmodule

// File: rtl/cm_ref_counter.sv
module cm_ref_counter #(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned REF_HZ = 24_000_000,
  parameter int unsigned CW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] count
);
  localparam int unsigned AW = $clog2(CLK_HZ) + 2;
  localparam logic [AW-1:0] STEP = AW'(REF_HZ);
  localparam logic [AW-1:0] WRAP = AW'(CLK_HZ);

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  assign sum = acc + STEP;

  // fractional rate: one count each time the phase passes a full clock period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      count <= '0;
    end else if (sum >= WRAP) begin
      acc   <= sum - WRAP;
      count <= count + 1'b1;
    end else begin
      acc   <= sum;
    end
  end
endmodule

// File: rtl/cm_irq_group.sv
module cm_irq_group #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_ens_we,
  input  logic          irq_enc_we,
  input  logic          fiq_ens_we,
  input  logic          fiq_enc_we,
  input  logic          soft_set_we,
  input  logic          soft_clr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] irq_en,
  output logic [DW-1:0] fiq_en,
  output logic          level,
  output logic          int_out
);
  cm_setclr_reg #(.W(DW), .RST('0)) u_irq_en (
    .clk(clk), .rst_n(rst_n), .set_we(irq_ens_we), .clr_we(irq_enc_we),
    .wdata(wdata), .q(irq_en)
  );

  cm_setclr_reg #(.W(DW), .RST('0)) u_fiq_en (
    .clk(clk), .rst_n(rst_n), .set_we(fiq_ens_we), .clr_we(fiq_enc_we),
    .wdata(wdata), .q(fiq_en)
  );

  cm_setclr_reg #(.W(1), .RST(1'b0)) u_level (
    .clk(clk), .rst_n(rst_n), .set_we(soft_set_we), .clr_we(soft_clr_we),
    .wdata(wdata[0]), .q(level)
  );

  assign int_out = level & (irq_en[0] | fiq_en[0]);
endmodule

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs
  import cm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned REF_HZ = 24_000_000,
  parameter int unsigned MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              status_led,
  output logic              boot_flash_en,
  output logic              reset_req,
  output logic              core_int
);
  localparam int unsigned DW      = 32;
  localparam int unsigned ID_BITS = 6;
  localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(1 << ID_BITS);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned wi);
    return a == ADDR_W'(wi);
  endfunction

  logic we_osc, we_lock, we_aux, we_ctrl;
  logic we_fs, we_fc, we_ns, we_nc;
  logic we_ies, we_iec, we_fes, we_fec, we_ss, we_sc;

  assign we_osc  = bus_wr && hit(bus_addr, WI_OSC);
  assign we_lock = bus_wr && hit(bus_addr, WI_LOCK);
  assign we_aux  = bus_wr && hit(bus_addr, WI_AUXOSC);
  assign we_ctrl = bus_wr && hit(bus_addr, WI_CTRL);
  assign we_fs   = bus_wr && hit(bus_addr, WI_FLAG_SET);
  assign we_fc   = bus_wr && hit(bus_addr, WI_FLAG_CLR);
  assign we_ns   = bus_wr && hit(bus_addr, WI_NV_SET);
  assign we_nc   = bus_wr && hit(bus_addr, WI_NV_CLR);
  assign we_ies  = bus_wr && hit(bus_addr, WI_IRQ_ENS);
  assign we_iec  = bus_wr && hit(bus_addr, WI_IRQ_ENC);
  assign we_fes  = bus_wr && hit(bus_addr, WI_FIQ_ENS);
  assign we_fec  = bus_wr && hit(bus_addr, WI_FIQ_ENC);
  assign we_ss   = bus_wr && hit(bus_addr, WI_SOFT_SET);
  assign we_sc   = bus_wr && hit(bus_addr, WI_SOFT_CLR);

  // keyed oscillator settings
  logic [15:0]   lock_q;
  logic          unlocked;
  logic [DW-1:0] osc_q, aux_q;

  cm_keyed_osc #(.DW(DW)) u_osc (
    .clk(clk), .rst_n(rst_n), .lock_we(we_lock), .osc_we(we_osc), .aux_we(we_aux),
    .wdata(bus_wdata), .lock_q(lock_q), .unlocked(unlocked), .osc_q(osc_q), .aux_q(aux_q)
  );

  // control register: only LED and remap bits are kept
  logic ctrl_led, ctrl_remap, rst_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_led   <= 1'b0;
      ctrl_remap <= 1'b0;
      rst_pulse  <= 1'b0;
    end else begin
      rst_pulse <= we_ctrl && bus_wdata[CB_RESET];
      if (we_ctrl) begin
        ctrl_led   <= bus_wdata[CB_LED];
        ctrl_remap <= bus_wdata[CB_REMAP];
      end
    end
  end

  assign status_led    = ctrl_led;
  assign boot_flash_en = ~ctrl_remap;
  assign reset_req     = rst_pulse;

  // flag pairs
  logic [DW-1:0] flags_q, nvflags_q;

  cm_setclr_reg #(.W(DW), .RST('0)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_we(we_fs), .clr_we(we_fc), .wdata(bus_wdata), .q(flags_q)
  );

  cm_setclr_reg #(.W(DW), .RST('0)) u_nvflags (
    .clk(clk), .rst_n(rst_n), .set_we(we_ns), .clr_we(we_nc), .wdata(bus_wdata), .q(nvflags_q)
  );

  // reference counter
  logic [DW-1:0] ref_count;

  cm_ref_counter #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .CW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count(ref_count)
  );

  // local interrupt group
  logic [DW-1:0] irq_en, fiq_en;
  logic          level;

  cm_irq_group #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .irq_ens_we(we_ies), .irq_enc_we(we_iec), .fiq_ens_we(we_fes), .fiq_enc_we(we_fec),
    .soft_set_we(we_ss), .soft_clr_we(we_sc), .wdata(bus_wdata),
    .irq_en(irq_en), .fiq_en(fiq_en), .level(level), .int_out(core_int)
  );

  // read multiplexer
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] lvl_w;

  assign lvl_w = DW'(level);

  always_comb begin
    rd_mux = '0;
    if (bus_addr >= ID_BASE) begin
      rd_mux = DW'(id_byte(bus_addr[ID_BITS-1:0], MEM_MB));
    end else begin
      case (bus_addr)
        ADDR_W'(WI_OSC):      rd_mux = osc_q;
        ADDR_W'(WI_CTRL):     rd_mux = DW'({ctrl_remap, 1'b0, ctrl_led});
        ADDR_W'(WI_LOCK):     rd_mux = DW'({unlocked, lock_q});
        ADDR_W'(WI_AUXOSC):   rd_mux = aux_q;
        ADDR_W'(WI_SDRAM):    rd_mux = SDRAM_RST;
        ADDR_W'(WI_INIT):     rd_mux = INIT_RST;
        ADDR_W'(WI_COUNT):    rd_mux = ref_count;
        ADDR_W'(WI_FLAG_SET): rd_mux = flags_q;
        ADDR_W'(WI_NV_SET):   rd_mux = nvflags_q;
        ADDR_W'(WI_IRQ_STAT): rd_mux = lvl_w & irq_en;
        ADDR_W'(WI_IRQ_RAW):  rd_mux = lvl_w;
        ADDR_W'(WI_IRQ_ENS):  rd_mux = irq_en;
        ADDR_W'(WI_SOFT_SET): rd_mux = lvl_w;
        ADDR_W'(WI_FIQ_STAT): rd_mux = lvl_w & fiq_en;
        ADDR_W'(WI_FIQ_RAW):  rd_mux = lvl_w;
        ADDR_W'(WI_FIQ_ENS):  rd_mux = fiq_en;
        default:              rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cm_ctrl_regs_chk.sv
module cm_ctrl_regs_chk #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       wdata_lo,
  input logic              bus_rvalid,
  input logic              boot_flash_en,
  input logic              reset_req,
  input logic              core_int,
  input logic              unlocked,
  input logic [15:0]       lock_q,
  input logic [31:0]       osc_q,
  input logic [31:0]       ref_count
);
  // R1
  locked_osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && !unlocked) |=> osc_q == $past(osc_q));

  // R2
  lock_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(5)) |=> lock_q == $past(wdata_lo));

  // R4
  reset_req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(3) && wdata_lo[3]) |=> reset_req);

  // R4
  reset_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R5
  flash_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(3)) |=> boot_flash_en == !$past(wdata_lo[2]));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_count == $past(ref_count)) || (ref_count == $past(ref_count) + 32'd1));

  // R11
  soft_clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(21) && wdata_lo[0]) |=> !core_int);

  // R14
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R14
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind cm_ctrl_regs cm_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[15:0]), .bus_rvalid(bus_rvalid), .boot_flash_en(boot_flash_en),
  .reset_req(reset_req), .core_int(core_int), .unlocked(unlocked), .lock_q(lock_q),
  .osc_q(osc_q), .ref_count(ref_count)
);

// File: tb/cm_ctrl_regs_test.sv
module cm_ctrl_regs_test;
  localparam int unsigned AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          status_led, boot_flash_en, reset_req, core_int;

  always #4 clk = ~clk;

  cm_ctrl_regs #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .status_led(status_led), .boot_flash_en(boot_flash_en),
    .reset_req(reset_req), .core_int(core_int)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  bit          cmp_q[$];
  string       tag_q[$];
  logic [31:0] cap_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R14 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        bit c;
        string t;
        e = exp_q.pop_front();
        c = cmp_q.pop_front();
        t = tag_q.pop_front();
        if (c) check(t, bus_rdata, e);
        else   cap_q.push_back(bus_rdata);
      end
    end
  end

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int unsigned a, input logic [31:0] e, input string t);
    exp_q.push_back(e); cmp_q.push_back(1'b1); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_cap(input int unsigned a);
    exp_q.push_back('0); cmp_q.push_back(1'b0); tag_q.push_back("cap");
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R5 flash after reset", 32'(boot_flash_en), 32'd1);
    check("R3 led after reset", 32'(status_led), 32'd0);
    check("R11 int after reset", 32'(core_int), 32'd0);
    rd(0,  32'h0100_0048, "R12 osc reset");
    rd(7,  32'h0007_FEFF, "R12 auxosc reset");
    rd(8,  32'h0001_1122, "R12 sdram reset");
    rd(9,  32'h0000_0112, "R12 init reset");
    rd(3,  32'h0, "R12 ctrl reset");
    rd(5,  32'h0, "R12 lock reset");
    rd(12, 32'h0, "R12 flags reset");
    rd(18, 32'h0, "R12 irq enable reset");

    // R1 locked writes ignored
    wr(0, 32'h1234_5678);
    wr(7, 32'h0000_0055);
    rd(0, 32'h0100_0048, "R1 osc locked");
    rd(7, 32'h0007_FEFF, "R1 auxosc locked");
    // R2 key and upper bits dropped
    wr(5, 32'hFFFF_A05F);
    rd(5, 32'h0001_A05F, "R2 lock unlocked view");
    wr(0, 32'hDEAD_BEEF);
    wr(7, 32'h0000_0055);
    rd(0, 32'hDEAD_BEEF, "R1 osc unlocked");
    rd(7, 32'h0000_0055, "R1 auxosc unlocked");
    wr(5, 32'h0000_A05E);
    rd(5, 32'h0000_A05E, "R2 lock wrong key");
    wr(7, 32'h0000_0099);
    rd(7, 32'h0000_0055, "R1 auxosc relocked");

    // R3 R4 R5 control
    wr(3, 32'hFFFF_FFFF);
    check("R4 reset_req pulse", 32'(reset_req), 32'd1);
    check("R3 led on", 32'(status_led), 32'd1);
    check("R5 flash off", 32'(boot_flash_en), 32'd0);
    @(negedge clk);
    check("R4 reset_req drops", 32'(reset_req), 32'd0);
    rd(3, 32'h0000_0005, "R3 R4 ctrl readback");
    wr(3, 32'h0000_0002);
    check("R4 no pulse without bit3", 32'(reset_req), 32'd0);
    check("R5 flash back on", 32'(boot_flash_en), 32'd1);
    check("R3 led off", 32'(status_led), 32'd0);
    rd(3, 32'h0, "R3 ctrl bit1 dropped");

    // R6 R7 flags
    wr(12, 32'h0000_F0F0);
    wr(12, 32'h0100_0000);
    wr(13, 32'h0000_00F0);
    rd(12, 32'h0100_F000, "R6 flags set clear");
    wr(14, 32'h0000_0003);
    wr(15, 32'h0000_0001);
    rd(14, 32'h0000_0002, "R7 nvflags set clear");
    rd(13, 32'h0, "R14 clear port reads zero");

    // R9 R10 R11 interrupts
    wr(18, 32'h0000_0003);
    rd(18, 32'h0000_0003, "R9 irq enable set");
    wr(20, 32'hFFFF_FFFE);
    rd(20, 32'h0, "R10 bit0 only");
    check("R11 no level no int", 32'(core_int), 32'd0);
    wr(20, 32'h0000_0001);
    check("R11 int raised", 32'(core_int), 32'd1);
    rd(20, 32'h1, "R10 level set");
    rd(16, 32'h1, "R9 irq status");
    rd(17, 32'h1, "R9 irq raw");
    rd(24, 32'h0, "R9 fiq status masked");
    wr(26, 32'h0000_0001);
    rd(24, 32'h1, "R9 fiq status");
    rd(26, 32'h1, "R9 fiq enable");
    wr(19, 32'h0000_0003);
    rd(16, 32'h0, "R9 irq masked after clear");
    check("R11 int via fiq mask", 32'(core_int), 32'd1);
    wr(27, 32'h0000_0001);
    check("R11 int off no masks", 32'(core_int), 32'd0);
    rd(25, 32'h1, "R9 fiq raw");
    wr(26, 32'h0000_0001);
    wr(21, 32'hFFFF_FFFE);
    check("R10 clear needs bit0", 32'(core_int), 32'd1);
    wr(21, 32'h0000_0001);
    check("R11 int off after clear", 32'(core_int), 32'd0);
    rd(17, 32'h0, "R10 level cleared");

    // R13 identification window
    rd(64, 32'h80, "R13 id byte0");
    rd(65, 32'h08, "R13 id byte1");
    rd(66, 32'h04, "R13 id byte2");
    rd(95, 32'h20, "R13 id density");
    rd(100, 32'h00, "R13 id zero");
    wr(64, 32'h0000_0011);
    rd(64, 32'h80, "R13 id write ignored");
    rd(40, 32'h0, "R14 unmapped");

    // R8 counter: reads 125 cycles apart
    rd_cap(10);
    repeat (123) @(negedge clk);
    rd_cap(10);
    repeat (3) @(negedge clk);
    if (cap_q.size() == 2) check("R8 counter rate", cap_q[1] - cap_q[0], 32'd24);
    else check("R8 counter captures", 32'(cap_q.size()), 32'd2);
    check("R14 all reads returned", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule